// File: doc/BRIEF.md
# Page Rewrite Sequencer

This block takes a byte stream framed by an active-low select and carries out one command: rewriting a whole page of a small on-chip page memory through one of two page buffers. A frame carries a command byte and then three address bytes. The command byte chooses the buffer. A 12-bit page number sits inside the 24 address bits. The operation runs only once the select is released. It then walks through three timed states. First the page is copied into the chosen buffer. Next the page is erased to all ones. Last the buffer is programmed back into the same page. A busy output stays high from the first of these states to the end of the last.

The state machine has four states. IDLE waits for a command. XFER is the page-to-buffer copy. ERASE is the built-in erase. PROG writes the buffer back to the page. It has four transitions:
- IDLE to XFER, on a valid frame whose select rise is sampled while idle.
- XFER to ERASE, when the copy timer expires, committing the copy.
- ERASE to PROG, when the erase timer expires, filling the page with 0xFF.
- PROG to IDLE, when the program timer expires, writing the buffer into the page.

Each phase length is a parameter. A plain load port and a plain read port give neighbouring logic access to the page memory and the buffers.

Top module: `rw_page_rewrite`

## Requirements
- R1: After reset, busy is low and every byte of the page memory and of both buffers reads 0x00.
- R2: Command byte 0x58 selects buffer 1 (read/load target 1) and 0x59 selects buffer 2 (target 2). Any other command byte starts nothing.
- R3: The three address bytes form a 24-bit value, most significant byte first. Bits 20 to 9 are the page number. Bits 23 to 21 and 8 to 0 are ignored. The page used is the page number modulo MEM_PAGES.
- R4: An operation starts only at a rising edge of cs_n sampled while idle. Busy stays low while bytes arrive and while cs_n is held low after a full frame.
- R5: A frame with fewer than four bytes is discarded. Bytes after the fourth do not change the captured command.
- R6: XFER_CYCLES cycles after busy rises, the selected buffer holds the page, and the other buffer is unchanged.
- R7: From XFER_CYCLES+ERASE_CYCLES cycles after busy rises until the end of the operation, every byte of the page reads 0xFF.
- R8: Busy goes high in the cycle after the sampled select rise. It stays high for exactly XFER_CYCLES+ERASE_CYCLES+PROG_CYCLES cycles. At its fall the page holds the buffer contents.
- R9: No busy period lasts longer than MAX_REWRITE_CYCLES cycles.
- R10: While busy, load-port writes and complete frames have no effect. This includes a frame whose select rise is sampled in the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| byte_valid | input | 1 | Byte strobe, taken only while cs_n is low |
| byte_in | input | 8 | Command or address byte |
| ld_en | input | 1 | Load-port write enable, honoured only when idle |
| ld_tgt | input | 2 | Load target: 0 page memory, 1 buffer 1, 2 buffer 2 |
| ld_page | input | $clog2(MEM_PAGES) | Page for a page-memory load |
| ld_idx | input | $clog2(PAGE_BYTES) | Byte index within page or buffer |
| ld_data | input | 8 | Load data |
| rd_tgt | input | 2 | Read target, same encoding as ld_tgt |
| rd_page | input | $clog2(MEM_PAGES) | Page for a page-memory read |
| rd_idx | input | $clog2(PAGE_BYTES) | Byte index for a read |
| rd_data | output | 8 | Combinational read data |
| busy | output | 1 | High while a rewrite is in progress |

## Verification
Two events can fall in the same cycle: a new frame's select rise, and the final PROG cycle in which busy drops. The bench times a complete frame during an operation so that its rise is sampled exactly on the last busy edge. It then requires busy to stay low afterwards, with the page equal to the buffer. A second pair is a byte strobe that coincides with the select rise. That byte must be dropped, and the command must run with the address from the first three address bytes.

// File: rtl/rw_pkg.sv
package rw_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_XFER,
        S_ERASE,
        S_PROG
    } rw_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_TO_BUF,
        OP_ERASE,
        OP_TO_PAGE
    } rw_op_e;

    localparam logic [7:0] OPC_REWRITE_B1 = 8'h58;
    localparam logic [7:0] OPC_REWRITE_B2 = 8'h59;
    localparam int         CMD_BYTES      = 4;

endpackage

// File: rtl/rw_cmd_capture.sv
module rw_cmd_capture
    import rw_pkg::*;
#(
    parameter int PAGE_AW  = 12,
    parameter int PAGE_LSB = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               byte_valid,
    input  logic [7:0]         byte_in,
    output logic               cmd_ready,
    output logic               cmd_buf,
    output logic [PAGE_AW-1:0] cmd_page
);

    localparam logic [2:0] CNT_FULL = 3'(CMD_BYTES);

    logic        cs_q;
    logic [2:0]  cnt_q;
    logic [7:0]  opc_q;
    logic [23:0] adr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            cnt_q <= '0;
            opc_q <= '0;
            adr_q <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                cnt_q <= '0;
            end else if (byte_valid && (cnt_q < CNT_FULL)) begin
                if (cnt_q == 3'd0) begin
                    opc_q <= byte_in;
                end else begin
                    adr_q <= {adr_q[15:0], byte_in};
                end
                cnt_q <= cnt_q + 3'd1;
            end
        end
    end

    logic rose;
    logic opc_ok;

    always_comb begin
        rose      = cs_n && !cs_q;
        opc_ok    = (opc_q == OPC_REWRITE_B1) || (opc_q == OPC_REWRITE_B2);
        cmd_ready = rose && (cnt_q == CNT_FULL) && opc_ok;
        cmd_buf   = (opc_q == OPC_REWRITE_B2);
        cmd_page  = adr_q[PAGE_LSB +: PAGE_AW];
    end

    // R5: bytes beyond the fourth leave the captured address alone
    p_extra_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && byte_valid && cnt_q == CNT_FULL) |=> $stable(adr_q) && $stable(opc_q));

endmodule

// File: rtl/rw_timer.sv
module rw_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb zero = (cnt_q == '0);

    // R8: phase timing depends on a steady one-per-cycle countdown
    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rw_page_store.sv
module rw_page_store
    import rw_pkg::*;
#(
    parameter int MEM_PAGES  = 8,
    parameter int PAGE_BYTES = 8,
    localparam int PG_W      = $clog2(MEM_PAGES),
    localparam int IX_W      = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  rw_op_e          op,
    input  logic [PG_W-1:0] op_page,
    input  logic            op_buf,
    input  logic            ld_en,
    input  logic [1:0]      ld_tgt,
    input  logic [PG_W-1:0] ld_page,
    input  logic [IX_W-1:0] ld_idx,
    input  logic [7:0]      ld_data,
    input  logic [1:0]      rd_tgt,
    input  logic [PG_W-1:0] rd_page,
    input  logic [IX_W-1:0] rd_idx,
    output logic [7:0]      rd_data
);

    logic [MEM_PAGES-1:0][PAGE_BYTES-1:0][7:0] main_q;
    logic [1:0][PAGE_BYTES-1:0][7:0]           buf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= '0;
            buf_q  <= '0;
        end else begin
            unique case (op)
                OP_TO_BUF:  buf_q[op_buf]   <= main_q[op_page];
                OP_ERASE:   main_q[op_page] <= '1;
                OP_TO_PAGE: main_q[op_page] <= buf_q[op_buf];
                OP_NONE: begin
                    if (ld_en && !busy) begin
                        unique case (ld_tgt)
                            2'd0:    main_q[ld_page][ld_idx] <= ld_data;
                            2'd1:    buf_q[0][ld_idx]        <= ld_data;
                            2'd2:    buf_q[1][ld_idx]        <= ld_data;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (rd_tgt)
            2'd0:    rd_data = main_q[rd_page][rd_idx];
            2'd1:    rd_data = buf_q[0][rd_idx];
            2'd2:    rd_data = buf_q[1][rd_idx];
            default: rd_data = 8'h00;
        endcase
    end

    // R7: the erase step leaves the whole page at all ones
    p_erase_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ERASE) |=> (main_q[$past(op_page)] == '1));

    // R6: the copy step places the old page into the chosen buffer
    p_copy_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TO_BUF) |=> (buf_q[$past(op_buf)] == $past(main_q[op_page])));

    // R10: no load-port write lands while an operation is running
    p_load_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op == OP_NONE) |=> ($stable(main_q) && $stable(buf_q)));

endmodule

// File: rtl/rw_page_rewrite.sv
module rw_page_rewrite
    import rw_pkg::*;
#(
    parameter int MEM_PAGES          = 8,
    parameter int PAGE_BYTES         = 8,
    parameter int XFER_CYCLES        = 6,
    parameter int ERASE_CYCLES       = 4,
    parameter int PROG_CYCLES        = 8,
    parameter int MAX_REWRITE_CYCLES = 24,
    localparam int PG_W              = $clog2(MEM_PAGES),
    localparam int IX_W              = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            byte_valid,
    input  logic [7:0]      byte_in,
    input  logic            ld_en,
    input  logic [1:0]      ld_tgt,
    input  logic [PG_W-1:0] ld_page,
    input  logic [IX_W-1:0] ld_idx,
    input  logic [7:0]      ld_data,
    input  logic [1:0]      rd_tgt,
    input  logic [PG_W-1:0] rd_page,
    input  logic [IX_W-1:0] rd_idx,
    output logic [7:0]      rd_data,
    output logic            busy
);

    localparam int PAGE_AW  = 12;
    localparam int CYC_A    = (XFER_CYCLES > ERASE_CYCLES) ? XFER_CYCLES : ERASE_CYCLES;
    localparam int CYC_MAX  = (CYC_A > PROG_CYCLES) ? CYC_A : PROG_CYCLES;
    localparam int TMR_W    = $clog2(CYC_MAX + 1);
    localparam int RUN_W    = $clog2(MAX_REWRITE_CYCLES + 2);

    logic               cmd_ready;
    logic               cmd_buf;
    logic [PAGE_AW-1:0] cmd_page;

    rw_cmd_capture #(
        .PAGE_AW  (PAGE_AW),
        .PAGE_LSB (9)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .cmd_ready  (cmd_ready),
        .cmd_buf    (cmd_buf),
        .cmd_page   (cmd_page)
    );

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;

    rw_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rw_state_e        state_q;
    rw_state_e        state_d;
    logic [PG_W-1:0]  page_q;
    logic             bsel_q;
    rw_op_e           op;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            page_q  <= '0;
            bsel_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && cmd_ready) begin
                page_q <= cmd_page[PG_W-1:0];
                bsel_q <= cmd_buf;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_ready) state_d = S_XFER;
            S_XFER:  if (tmr_zero)  state_d = S_ERASE;
            S_ERASE: if (tmr_zero)  state_d = S_PROG;
            S_PROG:  if (tmr_zero)  state_d = S_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        op       = OP_NONE;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_ready) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(XFER_CYCLES - 1);
                end
            end
            S_XFER: begin
                if (tmr_zero) begin
                    op       = OP_TO_BUF;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(ERASE_CYCLES - 1);
                end
            end
            S_ERASE: begin
                if (tmr_zero) begin
                    op       = OP_ERASE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PROG_CYCLES - 1);
                end
            end
            S_PROG: begin
                if (tmr_zero) op = OP_TO_PAGE;
            end
        endcase
        busy = (state_q != S_IDLE);
    end

    rw_page_store #(
        .MEM_PAGES  (MEM_PAGES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .op      (op),
        .op_page (page_q),
        .op_buf  (bsel_q),
        .ld_en   (ld_en),
        .ld_tgt  (ld_tgt),
        .ld_page (ld_page),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .rd_tgt  (rd_tgt),
        .rd_page (rd_page),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // busy run-length counter for the time-limit check
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            if (run_q != '1) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R9: the rewrite never outlasts its time limit
    p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(MAX_REWRITE_CYCLES));

    // R4: busy rises only after a sampled select rise
    p_start_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R8: phases run in fixed order
    p_phase_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XFER) |=> (state_q inside {S_XFER, S_ERASE}));

    // R10: a rise on the last busy cycle does not restart the engine
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROG && tmr_zero && cmd_ready) |=> (state_q == S_IDLE));

endmodule

// File: tb/tb_rw_page_rewrite.sv
`timescale 1ns/10ps
module tb_rw_page_rewrite;

    localparam int MP   = 8;
    localparam int PB   = 8;
    localparam int XC   = 6;
    localparam int EC   = 4;
    localparam int PC   = 8;
    localparam int MAXC = 24;
    localparam int T    = XC + EC + PC;
    localparam int PGW  = $clog2(MP);
    localparam int IXW  = $clog2(PB);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           byte_valid = 1'b0;
    logic [7:0]     byte_in = '0;
    logic           ld_en = 1'b0;
    logic [1:0]     ld_tgt = '0;
    logic [PGW-1:0] ld_page = '0;
    logic [IXW-1:0] ld_idx = '0;
    logic [7:0]     ld_data = '0;
    logic [1:0]     rd_tgt = '0;
    logic [PGW-1:0] rd_page = '0;
    logic [IXW-1:0] rd_idx = '0;
    logic [7:0]     rd_data;
    logic           busy;

    rw_page_rewrite #(
        .MEM_PAGES (MP), .PAGE_BYTES (PB), .XFER_CYCLES (XC),
        .ERASE_CYCLES (EC), .PROG_CYCLES (PC), .MAX_REWRITE_CYCLES (MAXC)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .byte_valid (byte_valid),
        .byte_in (byte_in), .ld_en (ld_en), .ld_tgt (ld_tgt), .ld_page (ld_page),
        .ld_idx (ld_idx), .ld_data (ld_data), .rd_tgt (rd_tgt), .rd_page (rd_page),
        .rd_idx (rd_idx), .rd_data (rd_data), .busy (busy)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [7:0] main_m [MP][PB];
    logic [7:0] buf_m  [2][PB];

    function automatic int exp_page(input logic [23:0] a);
        return int'((a >> 9) & 24'h000FFF) % MP;
    endfunction

    function automatic bit exp_valid(input logic [7:0] op, input int n);
        return ((op == 8'h58) || (op == 8'h59)) && (n >= 4);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int t, input int pg, input int ix, output logic [7:0] d);
        rd_tgt  = 2'(t);
        rd_page = PGW'(pg);
        rd_idx  = IXW'(ix);
        #0.2;
        d = rd_data;
    endtask

    task automatic cmp_page(input int pg, input string req);
        logic [7:0] d;
        bit ok = 1'b1;
        int a = 0;
        int e = 0;
        for (int i = 0; i < PB; i++) begin
            rd(0, pg, i, d);
            if (ok && d != main_m[pg][i]) begin ok = 1'b0; a = d; e = main_m[pg][i]; end
        end
        chk(ok, req, a, e);
    endtask

    task automatic cmp_buf(input int b, input string req);
        logic [7:0] d;
        bit ok = 1'b1;
        int a = 0;
        int e = 0;
        for (int i = 0; i < PB; i++) begin
            rd(b + 1, 0, i, d);
            if (ok && d != buf_m[b][i]) begin ok = 1'b0; a = d; e = buf_m[b][i]; end
        end
        chk(ok, req, a, e);
    endtask

    task automatic load(input int t, input int pg, input int ix, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_tgt = 2'(t); ld_page = PGW'(pg); ld_idx = IXW'(ix); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        if (t == 0) main_m[pg][ix] = v;
        else        buf_m[t-1][ix] = v;
    endtask

    function automatic logic [7:0] frame_byte(input logic [7:0] op, input logic [23:0] a, input int i);
        case (i)
            0: return op;
            1: return a[23:16];
            2: return a[15:8];
            3: return a[7:0];
            default: return 8'($urandom);
        endcase
    endfunction

    // full command: frame, optional hold, rise, then phase-by-phase checks
    task automatic run_op(input logic [7:0] op, input logic [23:0] a, input int n, input int hold,
                          input bit strobe_rise, input bit overlap, input bit load_busy);
        int pg = exp_page(a);
        int b  = int'(op[0]);
        int other = (pg + 1) % MP;
        int bcnt = 0;
        logic [7:0] d;
        logic [7:0] keep = main_m[(exp_page(a) + 1) % MP][0];
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_in    = frame_byte(op, a, i);
            chk(busy == 1'b0, "R4 busy during bytes", busy, 0);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R4 held select", busy, 0);
        end
        cs_n       = 1'b1;
        byte_valid = strobe_rise;
        byte_in    = 8'hA5;
        if (!exp_valid(op, n)) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                byte_valid = 1'b0;
                chk(busy == 1'b0, "R5 R2 no start", busy, 0);
            end
            cmp_buf(0, "R5 buffer untouched");
            cmp_page(pg, "R5 page untouched");
            return;
        end
        for (int j = 0; j <= T + 2; j++) begin
            @(negedge clk);
            byte_valid = 1'b0;
            ld_en      = 1'b0;
            if (busy) bcnt++;
            chk(busy == (j < T), "R8 busy window", busy, int'(j < T));
            if (load_busy && j == 2) begin
                ld_en = 1'b1; ld_tgt = 2'd0; ld_page = PGW'(other); ld_idx = '0; ld_data = ~keep;
            end
            if (overlap) begin
                if (j == T - 6) cs_n = 1'b0;
                if (j >= T - 5 && j <= T - 2) begin
                    byte_valid = 1'b1;
                    byte_in    = frame_byte(8'h58, 24'h000000, j - (T - 5));
                end
                if (j == T - 1) cs_n = 1'b1;
            end
            if (j == XC) begin
                for (int i = 0; i < PB; i++) buf_m[b][i] = main_m[pg][i];
                cmp_buf(b, "R6 R3 R2 selected buffer");
                cmp_buf(1 - b, "R6 other buffer");
            end
            if (j == XC + EC || j == T - 1) begin
                bit ok = 1'b1;
                for (int i = 0; i < PB; i++) begin
                    rd(0, pg, i, d);
                    if (d != 8'hFF) ok = 1'b0;
                end
                chk(ok, "R7 erased page", d, 8'hFF);
            end
            if (j == T) begin
                for (int i = 0; i < PB; i++) main_m[pg][i] = buf_m[b][i];
                cmp_page(pg, "R8 page programmed");
                if (load_busy) begin
                    rd(0, other, 0, d);
                    chk(d == keep, "R10 load while busy", d, keep);
                end
            end
        end
        chk(bcnt <= MAXC, "R9 time limit", bcnt, MAXC);
        chk(bcnt == T, "R8 busy length", bcnt, T);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        for (int p = 0; p < MP; p++) for (int i = 0; i < PB; i++) main_m[p][i] = 8'h00;
        for (int q = 0; q < 2; q++)  for (int i = 0; i < PB; i++) buf_m[q][i]  = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        cmp_page(3, "R1 reset page");
        cmp_buf(0, "R1 reset buffer 1");
        cmp_buf(1, "R1 reset buffer 2");

        for (int p = 0; p < MP; p++)
            for (int i = 0; i < PB; i++) load(0, p, i, 8'($urandom));
        for (int q = 0; q < 2; q++)
            for (int i = 0; i < PB; i++) load(q + 1, 0, i, 8'($urandom));

        // directed: reserved and don't-care bits set, page 5
        run_op(8'h58, 24'hE0_0BFF, 4, 0, 1'b0, 1'b0, 1'b0);
        // directed: buffer 2, select held low, strobe on rise, extra bytes
        run_op(8'h59, 24'h00_0600, 6, 5, 1'b1, 1'b0, 1'b0);
        // directed: short frame and wrong opcode
        run_op(8'h58, 24'h00_0400, 3, 0, 1'b0, 1'b0, 1'b0);
        run_op(8'h57, 24'h00_0400, 4, 0, 1'b0, 1'b0, 1'b0);
        // directed: load and frame while busy, rise on final busy edge
        run_op(8'h59, 24'h1F_F200, 4, 0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        cs_n = 1'b1;

        for (int k = 0; k < 24; k++) begin
            int r = int'($urandom % 10);
            logic [7:0] op = (r < 8) ? ((($urandom % 2) == 0) ? 8'h58 : 8'h59) : 8'($urandom);
            int n = (($urandom % 10) < 2) ? int'(1 + $urandom % 3) : int'(4 + ($urandom % 2) * 2);
            if (($urandom % 3) == 0) load(0, int'($urandom % MP), int'($urandom % PB), 8'($urandom));
            run_op(op, 24'($urandom), n, int'($urandom % 3), 1'($urandom), 1'b0, 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule